// File: doc/BRIEF.md
# DRAM power-up initialization sequencer

This block brings a DRAM device from power-on to normal operation. After reset it keeps the power-down pin low and drives deselect while the clock runs stable for a fixed time. The hold time is given in microseconds and converted to clock cycles, rounded up. It then raises the power-down pin, waits the power-down exit time, and issues a fixed series of command pairs. Each mode register write is a read-with-autoprecharge followed by the mode command carrying its op-code. Each auto-refresh is a write-with-autoprecharge followed by the refresh command. The minimum spacing after every pair comes from run-time timing inputs.

The order of the extended mode write, the mode write and the refresh pairs is chosen by a parameter, and so is the number of refreshes. A ready flag rises only when both of these hold: a set number of cycles have passed since the extended mode command, and the spacing after the last pair has elapsed. After that the bus stays at deselect. Pulling reset low at any time returns the block to the power-down hold and restarts the whole series.

Top module: `dinit_seq`

## Requirements
- R1: While reset is low, and for exactly STABLE_CYC = ceil(STABLE_US*1e6/CLK_PERIOD_PS) cycles after it is released, pd_o is 0, cmd_o is deselect and ready_o is 0.
- R2: pd_o rises in cycle STABLE_CYC after release and stays high until reset. The first command of the first pair appears exactly max(t_pdex_i,1) cycles after the rise, with deselect on every cycle in between.
- R3: cmd_o encodings are deselect=0, read-autoprecharge=1, write-autoprecharge=2, mode write=3, extended mode write=4, refresh=5. Every cycle that is not half of a pair carries deselect with addr_o=0.
- R4: A mode write pair is read-autoprecharge with addr_o=0, followed in the next cycle by the mode (3) or extended mode (4) command with mrs_op_i or emrs_op_i on addr_o.
- R5: A refresh pair is write-autoprecharge with addr_o=0, followed in the next cycle by refresh with addr_o=0. NUM_REF (at least 2) refresh pairs are issued.
- R6: The next pair starts exactly max(t_rsc_i,1) cycles after the second command of a mode write pair, and exactly max(t_refc_i,1) cycles after a refresh.
- R7: ORDER=0 issues extended mode, mode, then the refreshes. ORDER=1 issues mode, extended mode, then the refreshes. ORDER=2 issues the refreshes, then extended mode, then mode.
- R8: ready_o rises in cycle max(E+READY_DLY, C+T). E is the extended mode command cycle, C is the cycle of the last pair's second command, and T is that pair's spacing. ready_o then stays high and no further command is issued.
- R9: Asserting reset in the middle of the series at once forces pd_o low, ready_o low and deselect. After release, the series runs again from its first step.
- R10: A timing input of zero acts as one, which gives back-to-back pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| t_pdex_i | input | TW | Cycles from power-down release to first command |
| t_rsc_i | input | TW | Spacing after a mode write pair |
| t_refc_i | input | TW | Spacing after a refresh pair |
| emrs_op_i | input | AW | Extended mode op-code (DLL enable, driver strength) |
| mrs_op_i | input | AW | Mode op-code (CAS latency, burst type, burst length) |
| cmd_o | output | 3 | Encoded command |
| addr_o | output | AW | Address bus |
| pd_o | output | 1 | Power-down pin, low holds the device powered down |
| ready_o | output | 1 | Initialization complete |

## Verification
Two instances run side by side: one puts extended mode first with two refreshes, the other puts refreshes first with three. This separates the orderings and shows that the ready point is tied to the extended mode command, not to whatever comes last. Short spacings make ready depend on the 200-cycle delay, and a long refresh spacing makes it depend on the last refresh, so both terms of the ready rule are tried. All-zero timings check the clamp to back-to-back pairs. A reset pulled during a gap, followed by a clean rerun, checks the restart. Every command's cycle, code and address is compared against a scoreboard built from the requirements.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

  typedef enum logic [2:0] {
    CMD_DESL = 3'd0,
    CMD_RDA  = 3'd1,
    CMD_WRA  = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_EMRS = 3'd4,
    CMD_REF  = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    STEP_EMRS = 2'd0,
    STEP_MRS  = 2'd1,
    STEP_REF  = 2'd2
  } step_e;

  // order 0: ext, mode, refs; 1: mode, ext, refs; 2: refs, ext, mode
  function automatic step_e step_kind(int order, int num_ref, int idx);
    step_e k;
    case (order)
      1: k = (idx == 0) ? STEP_MRS : (idx == 1) ? STEP_EMRS : STEP_REF;
      2: k = (idx < num_ref) ? STEP_REF : (idx == num_ref) ? STEP_EMRS : STEP_MRS;
      default: k = (idx == 0) ? STEP_EMRS : (idx == 1) ? STEP_MRS : STEP_REF;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/dinit_hold_timer.sv
module dinit_hold_timer #(
  parameter int CYC = 80000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == CW'(CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (en_i && !done_o)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/dinit_gap_timer.sv
module dinit_gap_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          start_i,
  input  logic [TW-1:0] lim_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;
  logic [TW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign done_o  = cnt_inc >= {1'b0, lim_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= TW'(start_i);
    else if (~&cnt_q)       cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/dinit_ready_gate.sv
module dinit_ready_gate #(
  parameter int DLY = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic fin_i,
  output logic ready_o
);
  localparam int AGW = $clog2(DLY + 1);

  logic [AGW-1:0] age_q;
  logic           armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q   <= '0;
      armed_q <= 1'b0;
    end else if (arm_i) begin
      age_q   <= AGW'(1);
      armed_q <= 1'b1;
    end else if (armed_q && age_q != AGW'(DLY)) begin
      age_q   <= age_q + 1'b1;
    end
  end

  assign ready_o = fin_i && armed_q && (age_q == AGW'(DLY));

  // ready can never follow the extended mode command in the next cycle
  assert_ready_not_early_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !ready_o);

endmodule

// File: rtl/dinit_cmd_enc.sv
module dinit_cmd_enc
  import dinit_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          first_i,
  input  logic          second_i,
  input  step_e         kind_i,
  input  logic [AW-1:0] emrs_op_i,
  input  logic [AW-1:0] mrs_op_i,
  output cmd_e          cmd_o,
  output logic [AW-1:0] addr_o
);
  always_comb begin
    cmd_o  = CMD_DESL;
    addr_o = '0;
    if (first_i) begin
      cmd_o = (kind_i == STEP_REF) ? CMD_WRA : CMD_RDA;
    end else if (second_i) begin
      case (kind_i)
        STEP_EMRS: begin cmd_o = CMD_EMRS; addr_o = emrs_op_i; end
        STEP_MRS:  begin cmd_o = CMD_MRS;  addr_o = mrs_op_i;  end
        default:         cmd_o = CMD_REF;
      endcase
    end
  end

endmodule

// File: rtl/dinit_seq.sv
module dinit_seq
  import dinit_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 2500,
  parameter int STABLE_US     = 200,
  parameter int READY_DLY     = 200,
  parameter int NUM_REF       = 2,
  parameter int ORDER         = 0,
  parameter int TW            = 8,
  parameter int AW            = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] t_pdex_i,
  input  logic [TW-1:0] t_rsc_i,
  input  logic [TW-1:0] t_refc_i,
  input  logic [AW-1:0] emrs_op_i,
  input  logic [AW-1:0] mrs_op_i,
  output logic [2:0]    cmd_o,
  output logic [AW-1:0] addr_o,
  output logic          pd_o,
  output logic          ready_o
);
  localparam int STABLE_CYC = (STABLE_US * 1000000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int NUM_STEPS  = NUM_REF + 2;
  localparam int SW         = $clog2(NUM_STEPS);

  typedef enum logic [2:0] {
    ST_HOLD, ST_PDEX, ST_CMD1, ST_CMD2, ST_GAP, ST_FIN
  } state_e;

  state_e        state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  step_e         kind;
  logic          last_step, adv;
  logic          hold_done, tmr_done, tmr_load, tmr_start;
  logic [TW-1:0] pdex_lim, rsc_lim, refc_lim, gap_lim, tmr_lim;
  cmd_e          cmd;

  assign kind      = step_kind(ORDER, NUM_REF, int'(step_q));
  assign last_step = (step_q == SW'(NUM_STEPS - 1));

  // zero timing means one cycle
  assign pdex_lim = (t_pdex_i == '0) ? TW'(1) : t_pdex_i;
  assign rsc_lim  = (t_rsc_i  == '0) ? TW'(1) : t_rsc_i;
  assign refc_lim = (t_refc_i == '0) ? TW'(1) : t_refc_i;
  assign gap_lim  = (kind == STEP_REF) ? refc_lim : rsc_lim;
  assign tmr_lim  = (state_q == ST_PDEX) ? pdex_lim : gap_lim;

  dinit_hold_timer #(.CYC(STABLE_CYC)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_HOLD),
    .done_o (hold_done)
  );

  dinit_gap_timer #(.TW(TW)) u_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .start_i (tmr_start),
    .lim_i   (tmr_lim),
    .done_o  (tmr_done)
  );

  dinit_ready_gate #(.DLY(READY_DLY)) u_ready (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (state_q == ST_CMD2 && kind == STEP_EMRS),
    .fin_i   (state_q == ST_FIN),
    .ready_o (ready_o)
  );

  dinit_cmd_enc #(.AW(AW)) u_enc (
    .first_i   (state_q == ST_CMD1),
    .second_i  (state_q == ST_CMD2),
    .kind_i    (kind),
    .emrs_op_i (emrs_op_i),
    .mrs_op_i  (mrs_op_i),
    .cmd_o     (cmd),
    .addr_o    (addr_o)
  );

  assign cmd_o = cmd;
  assign pd_o  = (state_q != ST_HOLD);

  always_comb begin
    state_d   = state_q;
    step_d    = step_q;
    tmr_load  = 1'b0;
    tmr_start = 1'b0;
    adv       = 1'b0;
    case (state_q)
      ST_HOLD: if (hold_done) begin
        state_d  = ST_PDEX;
        tmr_load = 1'b1;
      end
      ST_PDEX: if (tmr_done) state_d = ST_CMD1;
      ST_CMD1: state_d = ST_CMD2;
      ST_CMD2: begin
        if (gap_lim == TW'(1)) begin
          adv = 1'b1;
        end else begin
          state_d   = ST_GAP;
          tmr_load  = 1'b1;
          tmr_start = 1'b1;
        end
      end
      ST_GAP: if (tmr_done) adv = 1'b1;
      ST_FIN: ;
      default: state_d = ST_HOLD;
    endcase
    if (adv) begin
      if (last_step) begin
        state_d = ST_FIN;
      end else begin
        state_d = ST_CMD1;
        step_d  = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assert_quiet_in_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_o |-> (cmd_o == CMD_DESL && !ready_o));

  assert_pd_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |=> pd_o);

  assert_cmd_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o <= CMD_REF);

  assert_mode_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_RDA |=> (cmd_o == CMD_MRS || cmd_o == CMD_EMRS));

  assert_ref_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_WRA |=> cmd_o == CMD_REF);

  assert_ready_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (ready_o && cmd_o == CMD_DESL));

endmodule

// File: tb/dinit_seq_test.sv
`timescale 1ns/1ps
module dinit_seq_test;
  localparam int TW   = 8;
  localparam int AW   = 15;
  localparam int CP   = 9000;
  localparam int SUS  = 3;
  localparam int RDLY = 200;
  localparam int S    = (SUS * 1000000 + CP - 1) / CP;   // 334 after round-up

  typedef struct packed {
    int             cyc;
    logic [2:0]     cmd;
    logic [AW-1:0]  addr;
  } ev_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic [TW-1:0] t_pdex = '0, t_rsc = '0, t_refc = '0;
  logic [AW-1:0] eop = '0, mop = '0;
  logic [2:0]    cmd_a, cmd_b;
  logic [AW-1:0] addr_a, addr_b;
  logic          pd_a, pd_b, rdy_a, rdy_b;

  dinit_seq #(.CLK_PERIOD_PS(CP), .STABLE_US(SUS), .READY_DLY(RDLY),
              .NUM_REF(2), .ORDER(0), .TW(TW), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .t_pdex_i(t_pdex), .t_rsc_i(t_rsc),
    .t_refc_i(t_refc), .emrs_op_i(eop), .mrs_op_i(mop),
    .cmd_o(cmd_a), .addr_o(addr_a), .pd_o(pd_a), .ready_o(rdy_a));

  dinit_seq #(.CLK_PERIOD_PS(CP), .STABLE_US(SUS), .READY_DLY(RDLY),
              .NUM_REF(3), .ORDER(2), .TW(TW), .AW(AW)) uut_b (
    .clk_i(clk), .rst_ni(rst_ni), .t_pdex_i(t_pdex), .t_rsc_i(t_rsc),
    .t_refc_i(t_refc), .emrs_op_i(eop), .mrs_op_i(mop),
    .cmd_o(cmd_b), .addr_o(addr_b), .pd_o(pd_b), .ready_o(rdy_b));

  int  cyc;
  int  n_chk = 0, n_fail = 0;
  int  exp_rdy_a, exp_rdy_b;
  bit  armed = 1'b0;
  ev_t q_a[$];
  ev_t q_b[$];

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int max1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // step kinds: 0 ext mode, 1 mode, 2 refresh
  function automatic int kind_of(input int order, input int nref, input int idx);
    if (order == 2) return (idx < nref) ? 2 : (idx == nref) ? 0 : 1;
    if (order == 1) return (idx == 0) ? 1 : (idx == 1) ? 0 : 2;
    return (idx == 0) ? 0 : (idx == 1) ? 1 : 2;
  endfunction

  task automatic build(input int inst, input int order, input int nref,
                       input int tp, input int trs, input int trf, output int rdy);
    int  t = S + max1(tp);
    int  e = 0;
    ev_t ev;
    for (int k = 0; k < nref + 2; k++) begin
      int kd = kind_of(order, nref, k);
      ev.cyc  = t;
      ev.cmd  = (kd == 2) ? 3'd2 : 3'd1;
      ev.addr = '0;
      if (inst == 0) q_a.push_back(ev); else q_b.push_back(ev);
      ev.cyc  = t + 1;
      ev.cmd  = (kd == 2) ? 3'd5 : (kd == 0) ? 3'd4 : 3'd3;
      ev.addr = (kd == 2) ? '0 : (kd == 0) ? eop : mop;
      if (inst == 0) q_a.push_back(ev); else q_b.push_back(ev);
      if (kd == 0) e = t + 1;
      t = t + 1 + ((kd == 2) ? max1(trf) : max1(trs));
    end
    rdy = (t > e + RDLY) ? t : e + RDLY;
  endtask

  task automatic mon_cmd(input int inst, input logic [2:0] c, input logic [AW-1:0] a);
    ev_t e;
    if (c == 3'd0) begin
      if (a != '0) chk(1'b0, "R3", "addr on deselect", int'(a), 0);
      return;
    end
    if ((inst == 0 && q_a.size() == 0) || (inst == 1 && q_b.size() == 0)) begin
      chk(1'b0, "R3", "unexpected command code", int'(c), 0);
      return;
    end
    e = (inst == 0) ? q_a.pop_front() : q_b.pop_front();
    n_chk++;
    if (cyc != e.cyc || c != e.cmd || a != e.addr) begin
      n_fail++;
      $display("FAIL R4/R5/R6/R7 inst%0d: actual cyc %0d cmd %0d addr %0h expected cyc %0d cmd %0d addr %0h",
               inst, cyc, c, a, e.cyc, e.cmd, e.addr);
    end
  endtask

  task automatic mon_lvl(input logic pd, input logic rdy, input int er);
    if (cyc == S - 1 || cyc == S || pd != (cyc >= S))
      chk(pd == (cyc >= S), "R1/R2", "pd_o level", int'(pd), int'(cyc >= S));
    if (cyc == er - 1 || cyc == er || rdy != (cyc >= er))
      chk(rdy == (cyc >= er), "R8", "ready_o level", int'(rdy), int'(cyc >= er));
  endtask

  always @(negedge clk) begin
    if (rst_ni && armed) begin
      mon_cmd(0, cmd_a, addr_a);
      mon_cmd(1, cmd_b, addr_b);
      mon_lvl(pd_a, rdy_a, exp_rdy_a);
      mon_lvl(pd_b, rdy_b, exp_rdy_b);
    end
  end

  task automatic run(input int tp, input int trs, input int trf,
                     input int eo, input int mo, input int abort_at);
    int last;
    t_pdex = TW'(tp); t_rsc = TW'(trs); t_refc = TW'(trf);
    eop = AW'(eo); mop = AW'(mo);
    q_a.delete(); q_b.delete();
    build(0, 0, 2, tp, trs, trf, exp_rdy_a);
    build(1, 2, 3, tp, trs, trf, exp_rdy_b);
    last = (exp_rdy_a > exp_rdy_b) ? exp_rdy_a : exp_rdy_b;
    @(posedge clk); #2;
    // R1: reset state
    chk(!pd_a && !rdy_a && cmd_a == 3'd0, "R1", "reset outputs", int'({pd_a, rdy_a, cmd_a}), 0);
    armed  = 1'b1;
    rst_ni = 1'b1;
    if (abort_at > 0) begin
      do begin @(posedge clk); #2; end while (cyc < abort_at);
      rst_ni = 1'b0;
      #1;
      // R9: mid-sequence reset
      chk(!pd_a && !pd_b, "R9", "pd_o after reset", int'({pd_a, pd_b}), 0);
      chk(!rdy_a && !rdy_b && cmd_a == 3'd0 && cmd_b == 3'd0, "R9", "ready/cmd after reset",
          int'({rdy_a, rdy_b, cmd_a, cmd_b}), 0);
      armed = 1'b0;
      q_a.delete(); q_b.delete();
      return;
    end
    do begin @(posedge clk); #2; end while (cyc < last + 6);
    // R8: series complete, nothing after ready
    chk(q_a.size() == 0, "R8", "inst0 pending commands", q_a.size(), 0);
    chk(q_b.size() == 0, "R8", "inst1 pending commands", q_b.size(), 0);
    chk(rdy_a && rdy_b, "R8", "ready held", int'({rdy_a, rdy_b}), 3);
    rst_ni = 1'b0;
    armed  = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    // mode-delay bound ready, distinct op-codes
    run(4, 3, 10, 'h0123, 'h0456, 0);
    // R10: all-zero timings act as one
    run(0, 0, 0, 'h7fff, 'h0001, 0);
    // R9: reset during the series, then a clean rerun
    run(2, 5, 60, 'h0aaa, 'h0555, S + 12);
    // refresh-spacing bound ready
    run(2, 5, 150, 'h02a5, 'h015a, 0);
    report();
  end

endmodule